// File: doc/BRIEF.md
# Sliding-Window Result Reuse Controller

This controller manages reuse of first-layer results when two convolution layers are fused and the first layer is replicated K×K times (K being the second layer's kernel size). The stored first-layer results form a K×K grid of slots, arranged as K physical columns of K slots each. On the first step of a row, every slot must be computed. On each later step the window slides by one stride. Only the K subblocks of the new column are computed, and they overwrite the oldest physical column in place. Nothing is shifted.

A modulo-K column counter serves as the write pointer. It also drives K column selects. Each select tells the second layer which physical column holds logical column j of the current window. Logical column 0 is always the oldest column. The analog arithmetic and the slot storage sit outside the block. It only issues compute requests, slot write enables and column selects.

Top module: `window_reuse_ctrl`

## Requirements
- R1: After reset the request mask and slot write enables are all zero, select j reads column j, and the first step is a full step.
- R2: A full step raises all K×K bits of the request mask in the cycle the step strobe is high. A step is full when the row-start flag is high in the same cycle, when the row-start flag was high in an earlier cycle after the last step, or when it is the first step after reset.
- R3: On an incremental step the request mask has exactly the K bits of the column at the write pointer set. Slot bit index = column × K + row.
- R4: The write pointer is 0 after a full step. It advances by one after each incremental step and wraps from K−1 to 0.
- R5: The slot write enables equal the request mask of the previous cycle.
- R6: From the cycle after a step, select j (bits j×CW upward) reads physical column (pointer + j) mod K. Logical column 0 is the oldest column and logical column K−1 is the newest.
- R7: A row-start flag raised without a step sets the pointer to 0 and makes the next step full. Raising it again before that step changes nothing further.
- R8: With no step strobe the request mask is zero and the selects do not change, unless a row-start flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Window step strobe |
| row_start_i | input | 1 | Marks a new row; the next step is full |
| req_mask_o | output | K*K | Subblock compute request, bit = column×K + row |
| slot_we_o | output | K*K | Slot write enables, one cycle after the request |
| sel_o | output | K*CW | Physical column for each logical column, CW bits each |

## Verification
The assertions run on every cycle. They check the following: a mask on any step has either K or K×K bits set, and no bits set without a step. The write enables trail the mask by one cycle. The selects always form a permutation of the columns. Logical column 0 advances by one after each incremental step and returns to 0 after a row start. Only the bench's scenarios can show a few behaviours that depend on a remembered history: which column an incremental step picks, the wrap of the pointer across several steps, and that a row start raised on its own turns the next step into a full one.

// File: rtl/window_reuse_ctrl.sv
module window_reuse_ctrl #(
  parameter int K = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic                 row_start_i,
  output logic [K*K-1:0]       req_mask_o,
  output logic [K*K-1:0]       slot_we_o,
  output logic [K*((K>1)?$clog2(K):1)-1:0] sel_o
);
  localparam int CW    = (K > 1) ? $clog2(K) : 1;
  localparam int SLOTS = K * K;

  logic [CW-1:0]    ptr;
  logic             full_pend;
  logic [SLOTS-1:0] col_mask;

  wire full_now = row_start_i | full_pend;

  for (genvar c = 0; c < K; c++) begin : g_col
    assign col_mask[c*K +: K] = {K{ptr == CW'(c)}};
  end

  assign req_mask_o = !step_i ? '0 : (full_now ? '1 : col_mask);

  for (genvar j = 0; j < K; j++) begin : g_sel
    wire [CW:0] raw = {1'b0, ptr} + (CW+1)'(j);
    assign sel_o[j*CW +: CW] = (raw >= (CW+1)'(K)) ? CW'(raw - (CW+1)'(K)) : CW'(raw);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      full_pend <= 1'b1;
      slot_we_o <= '0;
    end else begin
      slot_we_o <= req_mask_o;
      if (step_i) begin
        full_pend <= 1'b0;
        if (full_now)                 ptr <= '0;
        else if (ptr == CW'(K - 1))   ptr <= '0;
        else                          ptr <= ptr + 1'b1;
      end else if (row_start_i) begin
        full_pend <= 1'b1;
        ptr       <= '0;
      end
    end
  end
endmodule

// File: rtl/window_reuse_ctrl_chk.sv
module window_reuse_ctrl_chk #(
  parameter int K = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 step_i,
  input logic                 row_start_i,
  input logic [K*K-1:0]       req_mask_o,
  input logic [K*K-1:0]       slot_we_o,
  input logic [K*((K>1)?$clog2(K):1)-1:0] sel_o
);
  localparam int CW = (K > 1) ? $clog2(K) : 1;

  wire [CW-1:0] sel0 = sel_o[CW-1:0];
  logic [K-1:0] used;
  logic         in_range;

  always_comb begin
    used     = '0;
    in_range = 1'b1;
    for (int j = 0; j < K; j++) begin
      if (int'(sel_o[j*CW +: CW]) < K) used[sel_o[j*CW +: CW]] = 1'b1;
      else in_range = 1'b0;
    end
  end

  a_r2_rowstart_full: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && row_start_i |-> &req_mask_o);

  a_r3_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ($countones(req_mask_o) == K || $countones(req_mask_o) == K*K));

  a_r8_idle_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |-> req_mask_o == '0);

  a_r5_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> slot_we_o == $past(req_mask_o));

  a_r6_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    in_range && (&used));

  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !row_start_i && $countones(req_mask_o) == K |=>
      int'(sel0) == (int'($past(sel0)) + 1) % K);

  a_r7_rowstart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    row_start_i |=> sel0 == '0);

  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !row_start_i |=> $stable(sel_o));
endmodule

bind window_reuse_ctrl window_reuse_ctrl_chk #(.K(K)) u_chk (.*);

// File: tb/window_reuse_ctrl_test.sv
module window_reuse_ctrl_test;
  localparam int K  = 3;
  localparam int CW = 2;
  localparam int S  = K * K;

  logic clk = 0, rst_n = 0, step = 0, row_start = 0;
  logic [S-1:0]    req_mask, slot_we;
  logic [K*CW-1:0] sel;
  int n_tests = 0, n_fail = 0;
  int exp_ptr = 0;
  bit exp_full = 1;
  bit done = 0;

  always #10 clk = ~clk;

  window_reuse_ctrl #(.K(K)) uut (
    .clk(clk), .rst_n(rst_n), .step_i(step), .row_start_i(row_start),
    .req_mask_o(req_mask), .slot_we_o(slot_we), .sel_o(sel));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [K*CW-1:0] exp_sel(input int p);
    logic [K*CW-1:0] v;
    for (int j = 0; j < K; j++) v[j*CW +: CW] = CW'((p + j) % K);
    return v;
  endfunction

  task automatic do_step(input bit rs, input string req);
    bit full;
    logic [S-1:0] m;
    full = rs || exp_full;
    m = full ? {S{1'b1}} : (S'({K{1'b1}}) << (exp_ptr * K));
    step = 1; row_start = rs;
    #2;
    check(req_mask == m, {req, " mask"}, 32'(req_mask), 32'(m));
    @(negedge clk);
    step = 0; row_start = 0;
    exp_ptr  = full ? 0 : (exp_ptr + 1) % K;
    exp_full = 0;
    check(slot_we == m, "R5 write enables", 32'(slot_we), 32'(m));
    check(sel == exp_sel(exp_ptr), "R6 selects", 32'(sel), 32'(exp_sel(exp_ptr)));
  endtask

  task automatic t_reset();
    check(req_mask == '0, "R1 mask", 32'(req_mask), 0);
    check(slot_we == '0, "R1 we", 32'(slot_we), 0);
    check(sel == exp_sel(0), "R1 sel", 32'(sel), 32'(exp_sel(0)));
    do_step(0, "R1 R2 first step full");
  endtask

  task automatic t_incremental();
    for (int i = 0; i < 5; i++) do_step(0, "R3 R4 incremental");
  endtask

  task automatic t_row_start_alone();
    do_step(0, "R3 before row start");
    row_start = 1;
    @(negedge clk);
    row_start = 1;
    @(negedge clk);
    row_start = 0;
    exp_ptr = 0; exp_full = 1;
    check(sel == exp_sel(0), "R7 sel after row start", 32'(sel), 32'(exp_sel(0)));
    check(req_mask == '0, "R8 no step mask", 32'(req_mask), 0);
    do_step(0, "R7 pending full");
    do_step(0, "R4 after full ptr 0");
  endtask

  task automatic t_row_start_with_step();
    do_step(0, "R3 mid row");
    do_step(1, "R2 row start with step");
    do_step(0, "R3 after row start");
  endtask

  task automatic t_idle();
    logic [K*CW-1:0] s0;
    s0 = sel;
    repeat (4) @(negedge clk);
    check(req_mask == '0, "R8 idle mask", 32'(req_mask), 0);
    check(slot_we == '0, "R8 idle we", 32'(slot_we), 0);
    check(sel == s0, "R8 idle sel", 32'(sel), 32'(s0));
    do_step(0, "R3 after idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_incremental();
    t_row_start_alone();
    t_row_start_with_step();
    t_idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule